// File: doc/BRIEF.md
# SPI Clock Divisor Search Engine

This block works out the prescaler setting for a serial clock generator. A request gives two 32-bit numbers: the reference clock frequency and the bit rate wanted on the serial line. In the normal (two-stage) mode the generator divides the reference by a linear factor of 1 to 15 and then by a power of two from 1 to 128. The engine tries all eight power-of-two exponents. For each one it takes the smallest linear factor that keeps the serial clock at or below the request. It keeps the pair whose clock comes closest to the request and packs that pair into an 8-bit field. The linear factor and exponent occupy non-adjacent bit positions in that field.

A legacy mode serves older generators that only take even divisors from 4 to 30. In this mode one rounded-up division decides the outcome. If no setting can meet the request, the engine raises a reject flag instead of giving a field.

The engine is sequential. A start pulse on an idle engine captures the inputs. A shared restoring divider then runs two divisions per exponent. The engine signals completion with a one-cycle done pulse. The result stays on the outputs until the next request finishes. Driving the divisor onto an actual clock is left to the consumer of the field.

Top module: `spi_clkdiv_search`

## Requirements
- R1: A start pulse is taken only while busy is low. A start pulse during a search is ignored, and the result returned belongs to the request that started the search.
- R2: done is high for exactly one cycle per accepted request, and busy is low while done is high. reject and field keep their values from one done pulse to the next.
- R3: In two-stage mode, each exponent e from 0 to 7 gives a linear factor lin = ceil(floor(ref/2^e)/rate). Factors of 0 or above 15 are skipped.
- R4: The kept candidate is the one with the smallest error, where error = rate - floor(ref/(lin*2^e)). A later candidate replaces the kept one only if its error is strictly smaller, so on a tie the lower exponent wins.
- R5: The two-stage field is {e[2:1], 1'b0, e[0], lin[3:0]}: lin in bits 3:0, exponent bit 0 in bit 4, bit 5 always zero, and exponent bits 2:1 in bits 7:6.
- R6: In two-stage mode, reject is raised when no exponent gives a linear factor from 1 to 15. The field reads 0 whenever reject is high.
- R7: In legacy mode, d = ceil(ref/rate) is rounded up to the next even value. The request is rejected if d > 30. Otherwise d is raised to 4 if it is smaller, and the field is 16 + d/2.
- R8: A rate of 0 is rejected in either mode. done pulses in the cycle after start, and busy never rises.
- R9: After reset, busy, done and reject are low and the field is 0.
- R10: The mode and both frequencies are sampled only when a start is accepted. Changing them during a search does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, taken when idle |
| legacy_i | input | 1 | 1 selects the even-divisor legacy rule |
| ref_hz_i | input | 32 | Reference clock frequency |
| rate_hz_i | input | 32 | Requested serial bit rate |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| reject_o | output | 1 | No setting meets the request |
| field_o | output | 8 | Encoded prescaler field |

## Verification
The hardest behaviour to reach is the choice between candidates. Rejecting out-of-range factors, replacing a candidate only on a strictly smaller error, and keeping the lower exponent on a tie only show up when several exponents give legal factors with close errors. Random rates are therefore drawn as the reference shifted right by a random amount plus a small offset. This keeps the linear factor near the 1-to-15 window for a spread of exponents. Directed requests add an exact tie, a win at the top exponent, a full reject, and the legacy clamp and reject edges. While each search is running, the bench changes all the inputs and pulses start again, to show the first request is the one answered.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

  localparam int FIELD_W = 8;
  localparam int LIN_W   = 4;
  localparam int EXP_W   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LIN,
    ST_CLK,
    ST_NEXT,
    ST_FIN
  } search_st_t;

  // Split prescaler layout: exponent high bits sit above a reserved hole
  function automatic logic [FIELD_W-1:0] pack_field(input logic [LIN_W-1:0] lin,
                                                    input logic [EXP_W-1:0] ex);
    return {ex[2:1], 1'b0, ex[0], lin};
  endfunction

endpackage

// File: rtl/spi_div_restoring.sv
module spi_div_restoring #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);

  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  acc_q, qsh_q, dvs_q;
  logic [W:0]    shifted, diff;
  logic          fits;

  always_comb begin
    shifted = {acc_q, qsh_q[W-1]};
    fits    = shifted >= {1'b0, dvs_q};
    diff    = shifted - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      qsh_q  <= '0;
      dvs_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(W);
        acc_q  <= '0;
        qsh_q  <= dividend_i;
        dvs_q  <= divisor_i;
      end else if (busy_q) begin
        acc_q <= fits ? diff[W-1:0] : shifted[W-1:0];
        qsh_q <= {qsh_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = qsh_q;
  assign rem_o  = acc_q;

  // R3: the sequencer must never launch a division on top of a running one
  assert_go_idle_R3: assert property (@(posedge clk) disable iff (rst)
    go_i |-> !busy_q);
  // R8: zero rates are filtered before they reach the divider
  assert_no_zero_div_R8: assert property (@(posedge clk) disable iff (rst)
    go_i |-> divisor_i != '0);
  // R3: a finished division leaves a remainder below the divisor
  assert_rem_below_R3: assert property (@(posedge clk) disable iff (rst)
    done_q |-> acc_q < dvs_q);

endmodule

// File: rtl/spi_div_best_tracker.sv
module spi_div_best_tracker
  import spi_clkdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic [W-1:0]     init_err_i,
  input  logic             upd_i,
  input  logic [W-1:0]     err_i,
  input  logic [LIN_W-1:0] lin_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             found_o,
  output logic [LIN_W-1:0] best_lin_o,
  output logic [EXP_W-1:0] best_exp_o
);
  logic [W-1:0]     best_err_q;
  logic [LIN_W-1:0] best_lin_q;
  logic [EXP_W-1:0] best_exp_q;
  logic             take;

  assign take = upd_i && (err_i < best_err_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      best_err_q <= '0;
      best_lin_q <= '0;
      best_exp_q <= '0;
    end else if (clear_i) begin
      best_err_q <= init_err_i;
      best_lin_q <= '0;
      best_exp_q <= '0;
    end else if (take) begin
      best_err_q <= err_i;
      best_lin_q <= lin_i;
      best_exp_q <= exp_i;
    end
  end

  assign found_o    = (best_lin_q != '0) || (best_exp_q != '0);
  assign best_lin_o = best_lin_q;
  assign best_exp_o = best_exp_q;

  // R4: outside a clear the kept error can only shrink
  assert_err_monotonic_R4: assert property (@(posedge clk) disable iff (rst)
    !clear_i |=> best_err_q <= $past(best_err_q));
  // R4: the candidate only ever changes to a strictly better one
  assert_strict_improve_R4: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && upd_i && err_i >= best_err_q) |=> $stable(best_lin_q) && $stable(best_exp_q));

endmodule

// File: rtl/spi_clkdiv_search.sv
module spi_clkdiv_search
  import spi_clkdiv_pkg::*;
#(
  parameter int W        = 32,
  parameter int EXP_N    = 8,
  parameter int LIN_MAX  = 15,
  parameter int LEG_MIN  = 4,
  parameter int LEG_MAX  = 30,
  parameter int LEG_BASE = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         legacy_i,
  input  logic [31:0]  ref_hz_i,
  input  logic [31:0]  rate_hz_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         reject_o,
  output logic [7:0]   field_o
);
  localparam int EW = $clog2(EXP_N);

  search_st_t       state_q;
  logic             busy_q, done_q, reject_q, legacy_q;
  logic [7:0]       field_q, pend_field_q;
  logic             pend_rej_q;
  logic [W-1:0]     ref_q, rate_q, q_cur_q;
  logic [EW-1:0]    exp_q, nxt_exp;
  logic [LIN_W-1:0] lin_q;
  logic             div_go_q;
  logic [W-1:0]     div_a_q, div_b_q;

  logic             div_done;
  logic [W-1:0]     div_quot, div_rem;
  logic [W:0]       lin_full;
  logic             lin_ok;
  logic [W+1:0]     even_d;
  logic             leg_rej;
  logic [7:0]       leg_d, leg_field;
  logic             trk_clear, trk_upd, trk_found;
  logic [W-1:0]     cand_err;
  logic [LIN_W-1:0] best_lin;
  logic [EXP_W-1:0] best_exp;

  spi_div_restoring #(.W(W)) u_div (
    .clk        (clk),
    .rst        (rst),
    .go_i       (div_go_q),
    .dividend_i (div_a_q),
    .divisor_i  (div_b_q),
    .done_o     (div_done),
    .quot_o     (div_quot),
    .rem_o      (div_rem)
  );

  // ceiling of the finished division, plus the legacy even/clamp rule
  always_comb begin
    lin_full = {1'b0, div_quot} + (W+1)'(div_rem != '0);
    lin_ok   = (lin_full != '0) && (lin_full <= (W+1)'(LIN_MAX));
    even_d   = {1'b0, lin_full} + (W+2)'(lin_full[0]);
    leg_rej  = even_d > (W+2)'(LEG_MAX);
    if (even_d < (W+2)'(LEG_MIN)) leg_d = 8'(LEG_MIN);
    else                          leg_d = even_d[7:0];
    leg_field = 8'(LEG_BASE) + {1'b0, leg_d[7:1]};
    nxt_exp   = exp_q + 1'b1;
    cand_err  = rate_q - div_quot;
  end

  assign trk_clear = (state_q == ST_IDLE) && start_i;
  assign trk_upd   = (state_q == ST_CLK) && div_done;

  spi_div_best_tracker #(.W(W)) u_best (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (trk_clear),
    .init_err_i (rate_hz_i),
    .upd_i      (trk_upd),
    .err_i      (cand_err),
    .lin_i      (lin_q),
    .exp_i      (EXP_W'(exp_q)),
    .found_o    (trk_found),
    .best_lin_o (best_lin),
    .best_exp_o (best_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      busy_q       <= 1'b0;
      done_q       <= 1'b0;
      reject_q     <= 1'b0;
      field_q      <= '0;
      legacy_q     <= 1'b0;
      pend_field_q <= '0;
      pend_rej_q   <= 1'b0;
      ref_q        <= '0;
      rate_q       <= '0;
      q_cur_q      <= '0;
      exp_q        <= '0;
      lin_q        <= '0;
      div_go_q     <= 1'b0;
      div_a_q      <= '0;
      div_b_q      <= '0;
    end else begin
      done_q   <= 1'b0;
      div_go_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            ref_q    <= ref_hz_i;
            rate_q   <= rate_hz_i;
            legacy_q <= legacy_i;
            exp_q    <= '0;
            if (rate_hz_i == '0) begin
              done_q   <= 1'b1;
              reject_q <= 1'b1;
              field_q  <= '0;
            end else begin
              busy_q   <= 1'b1;
              div_go_q <= 1'b1;
              div_a_q  <= ref_hz_i;
              div_b_q  <= rate_hz_i;
              q_cur_q  <= ref_hz_i;
              state_q  <= ST_LIN;
            end
          end
        end
        ST_LIN: begin
          if (div_done) begin
            if (legacy_q) begin
              pend_rej_q   <= leg_rej;
              pend_field_q <= leg_rej ? 8'h00 : leg_field;
              state_q      <= ST_FIN;
            end else if (lin_ok) begin
              lin_q    <= lin_full[LIN_W-1:0];
              div_go_q <= 1'b1;
              div_a_q  <= q_cur_q;
              div_b_q  <= W'(lin_full[LIN_W-1:0]);
              state_q  <= ST_CLK;
            end else begin
              state_q <= ST_NEXT;
            end
          end
        end
        ST_CLK: begin
          if (div_done) state_q <= ST_NEXT;
        end
        ST_NEXT: begin
          if (exp_q == EW'(EXP_N - 1)) begin
            state_q <= ST_FIN;
          end else begin
            exp_q    <= nxt_exp;
            q_cur_q  <= ref_q >> nxt_exp;
            div_go_q <= 1'b1;
            div_a_q  <= ref_q >> nxt_exp;
            div_b_q  <= rate_q;
            state_q  <= ST_LIN;
          end
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
          if (legacy_q) begin
            reject_q <= pend_rej_q;
            field_q  <= pend_field_q;
          end else begin
            reject_q <= !trk_found;
            field_q  <= trk_found ? pack_field(best_lin, best_exp) : 8'h00;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign reject_o = reject_q;
  assign field_o  = field_q;

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  assert_field_held_R2: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> $stable(field_q) && $stable(reject_q));
  assert_reject_zero_R6: assert property (@(posedge clk) disable iff (rst)
    reject_q |-> field_q == 8'h00);
  assert_field_hole_R5: assert property (@(posedge clk) disable iff (rst)
    (done_q && !reject_q && !legacy_q) |-> (field_q[5] == 1'b0) && (field_q[3:0] != 4'h0));
  assert_legacy_range_R7: assert property (@(posedge clk) disable iff (rst)
    (done_q && !reject_q && legacy_q) |-> (field_q >= 8'(LEG_BASE + LEG_MIN/2)) &&
                                         (field_q <= 8'(LEG_BASE + LEG_MAX/2)));
  assert_capture_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i) |=> $stable(ref_q) && $stable(rate_q) && $stable(legacy_q));
  assert_exp_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CLK) |-> (lin_q != '0));

endmodule

// File: tb/spi_clkdiv_search_bench.sv
`timescale 1ns/1ps
module spi_clkdiv_search_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        legacy_i = 1'b0;
  logic [31:0] ref_hz_i = '0;
  logic [31:0] rate_hz_i = '0;
  logic        busy_o, done_o, reject_o;
  logic [7:0]  field_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spi_clkdiv_search u_spi_clkdiv_search (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .legacy_i  (legacy_i),
    .ref_hz_i  (ref_hz_i),
    .rate_hz_i (rate_hz_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .reject_o  (reject_o),
    .field_o   (field_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // Expected {reject, field}, computed from the requirement text
  function automatic logic [8:0] model(input longint unsigned rf, input longint unsigned rt, input bit leg);
    longint unsigned d, q, lin, c, err, best_err;
    int bl, be;
    if (rt == 0) return {1'b1, 8'h00};                     // R8
    if (leg) begin                                         // R7
      d = (rf + rt - 1) / rt;
      if (d[0]) d = d + 1;
      if (d > 30) return {1'b1, 8'h00};
      if (d < 4) d = 4;
      return {1'b0, 8'(16 + d / 2)};
    end
    best_err = rt; bl = 0; be = 0;
    for (int e = 0; e < 8; e++) begin                      // R3
      q = rf >> e;
      lin = (q + rt - 1) / rt;
      if (lin == 0 || lin > 15) continue;
      c = q / lin;
      err = rt - c;
      if (err < best_err) begin                            // R4
        best_err = err; bl = int'(lin); be = e;
      end
    end
    if (bl == 0 && be == 0) return {1'b1, 8'h00};          // R6
    return {1'b0, 2'(be >> 1), 1'b0, 1'(be), 4'(bl)};      // R5
  endfunction

  task automatic run(input logic [31:0] rf, input logic [31:0] rt, input bit leg, input string tag);
    logic [8:0] expv;
    int n;
    expv = model(rf, rt, leg);
    @(negedge clk);
    ref_hz_i = rf; rate_hz_i = rt; legacy_i = leg; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (busy_o) begin
      // R1 R10: disturb inputs and re-pulse start mid-search
      ref_hz_i = $urandom; rate_hz_i = $urandom | 32'd1; legacy_i = ~leg; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    n = 0;
    while (!done_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 5000, {tag, " R2 done timeout"}, 32'(n), 32'd5000);
    chk(!busy_o, {tag, " R2 busy low at done"}, 32'(busy_o), 32'd0);
    chk(reject_o == expv[8], {tag, " R6 R10 reject"}, 32'(reject_o), 32'(expv[8]));
    chk(field_o == expv[7:0], {tag, " R4 R10 field"}, 32'(field_o), 32'(expv[7:0]));
    @(negedge clk);
    chk(!done_o, {tag, " R2 single-cycle done"}, 32'(done_o), 32'd0);
    chk(field_o == expv[7:0], {tag, " R2 field held"}, 32'(field_o), 32'(expv[7:0]));
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rf, rt;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!busy_o && !done_o, "R9 busy/done after reset", {30'd0, busy_o, done_o}, 32'd0);
    chk(!reject_o && field_o == 8'h00, "R9 reject/field after reset", {23'd0, reject_o, field_o}, 32'd0);

    run(32'd100_000_000, 32'd25_000_000, 1'b0, "R3 exact lin4");
    run(32'd100, 32'd50, 1'b0, "R4 tie keeps exp0");          // expect 0x02
    run(32'd1000, 32'd7, 1'b0, "R5 win at exp7");             // expect 0xD1
    run(32'd10, 32'd100, 1'b0, "R3 ref below rate");
    run(32'd250_000_000, 32'd1000, 1'b0, "R6 no fit");
    run(32'd12345, 32'd0, 1'b0, "R8 zero rate");
    run(32'd12345, 32'd0, 1'b1, "R8 zero rate legacy");
    run(32'd100, 32'd50, 1'b1, "R7 clamp to 4");              // 0x12
    run(32'd100, 32'd3, 1'b1, "R7 over 30");                  // reject
    run(32'd100, 32'd7, 1'b1, "R7 odd rounds up");            // 0x18
    run(32'd30, 32'd1, 1'b1, "R7 exactly 30");                // 0x1F
    run(32'hFFFF_FFFF, 32'd1, 1'b0, "R6 max ref");
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R3 max both");

    for (int i = 0; i < 70; i++) begin
      rf = $urandom;
      if ($urandom_range(0, 4) == 0) rt = $urandom;
      else rt = (rf >> $urandom_range(0, 14)) + 32'($urandom_range(0, 3));
      run(rf, rt, $urandom_range(0, 3) == 0, "R4 random");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule